// File: doc/BRIEF.md
# Strobe-Driven Phase Detector and Divider Core

This block is the digital heart of a fixed-configuration frequency synthesizer. It runs entirely on one fast system clock. Reference edges and feedback (RF) edges arrive as single-cycle strobes. The reference stream is halved. The feedback stream is divided by 8, 16, 32 or 64, chosen by two static select pins. The two divided strobe streams drive a two-flip-flop phase-frequency detector. That detector produces pump-up and pump-down commands for an external charge pump.

Once both detector flip-flops are set, they stay set together for a fixed number of clock cycles and then clear. This coincident overlap removes the dead zone around zero phase error. A second pair of static pins picks one of four operating modes. Each mode fixes three things at once: what the monitor output shows, whether the two pump commands are swapped, and whether the pump is enabled or left floating with the loop open.

Top module: `pfd_synth_core`

## Requirements
- R1: The reference path emits one divided strobe for every 2 reference strobes. With mode 00, `up_o` stays low after a single reference strobe. It rises in the second cycle after the clock edge that samples the second reference strobe.
- R2: The feedback divide ratio follows `nsel_i`: 00 gives 8, 01 gives 16, 10 gives 32 and 11 gives 64 feedback strobes per divided strobe.
- R3: The divided reference sets the internal UP flip-flop and the divided feedback sets the internal DOWN flip-flop. Each one stays set until the coincidence clear.
- R4: When both flip-flops are set, they stay set together for exactly `CLR_DELAY` cycles (default 3) and then both clear in the same cycle.
- R5: A divided strobe that arrives while both flip-flops are set is held back. It sets its flip-flop in the first cycle after the clear.
- R6: Mode 00: the pump is enabled, `up_o`/`dn_o` follow UP/DOWN, and `mux_o` is constant 1.
- R7: Mode 01: `cp_en_o`, `up_o` and `dn_o` are 0 and `mux_o` shows the divided-reference strobe. The detector keeps its state, and that state reappears when the block returns to mode 00.
- R8: Mode 10: the pump is enabled with positive polarity, and `mux_o` shows the divided-feedback strobe.
- R9: Mode 11: the pump is enabled, `up_o` carries DOWN and `dn_o` carries UP, and `mux_o` is constant 0.
- R10: A change on `nsel_i` restarts the feedback count from zero, so the next divided strobe needs a full new ratio of strobes.
- R11: A synchronous active-low reset clears both dividers, both flip-flops and any held-back strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_stb | input | 1 | One-cycle reference edge strobe |
| fb_stb | input | 1 | One-cycle feedback edge strobe |
| nsel_i | input | 2 | Feedback ratio select |
| mode_i | input | 2 | Operating mode select |
| up_o | output | 1 | Pump-up command |
| dn_o | output | 1 | Pump-down command |
| cp_en_o | output | 1 | Pump enable (0 = float) |
| mux_o | output | 1 | Monitor output |

## Verification
A divider counter left in a wrong state shows up as a shifted strobe count on the pump command or on the monitor output. The error appears on the divided strobe after the corrupted count, so within at most 64 feedback strobes. A detector flip-flop stuck in a wrong state shows on `up_o`/`dn_o` in the very next cycle: either a command that never clears, or an overlap window whose length is not `CLR_DELAY`. A dropped held-back strobe shows one cycle after the clear as a missing rise of `up_o`.

// File: rtl/pfd_synth_pkg.sv
// Package: shared mode encoding for the synthesizer core.
// Assumes the two mode pins are static during normal operation.
package pfd_synth_pkg;
    typedef enum logic [1:0] {
        MD_ACTIVE_HI = 2'b00,
        MD_OPEN_REF  = 2'b01,
        MD_ACTIVE_FB = 2'b10,
        MD_INVERT_LO = 2'b11
    } mode_e;
endpackage

// File: rtl/strobe_div.sv
// strobe_div: counts input strobes and emits a one-cycle registered strobe
// on every (last_i+1)-th input strobe. The clear_i input restarts the count.
// Assumes last_i is stable except when clear_i is raised.
module strobe_div #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             stb_i,
    input  logic [CNT_W-1:0] last_i,
    output logic             div_o
);
    logic [CNT_W-1:0] cnt;

    // Count strobes and fire on the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt   <= '0;
            div_o <= 1'b0;
        end else begin
            div_o <= 1'b0;
            if (stb_i) begin
                if (cnt == last_i) begin
                    cnt   <= '0;
                    div_o <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pfd_detector.sv
// pfd_detector: two set-only flip-flops (UP from the reference, DOWN from the
// feedback). Once both are set, they clear together after CLR_DELAY cycles.
// Strobes that arrive during that window are held and applied after the clear.
// Assumes CLR_DELAY >= 1.
module pfd_detector #(
    parameter int CLR_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_ev,
    input  logic fb_ev,
    output logic up_q,
    output logic dn_q
);
    localparam int DLY_W = $clog2(CLR_DELAY + 1);

    logic [DLY_W-1:0] dly_cnt;
    logic             held_up;
    logic             held_dn;
    logic             both;

    // Coincidence flag that opens the clear window.
    always_comb both = up_q & dn_q;

    // Set, window count, clear and deferred-strobe handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            held_up <= 1'b0;
            held_dn <= 1'b0;
            dly_cnt <= '0;
        end else if (both) begin
            held_up <= held_up | ref_ev;
            held_dn <= held_dn | fb_ev;
            if (dly_cnt == DLY_W'(CLR_DELAY - 1)) begin
                up_q    <= 1'b0;
                dn_q    <= 1'b0;
                dly_cnt <= '0;
            end else begin
                dly_cnt <= dly_cnt + 1'b1;
            end
        end else begin
            up_q    <= up_q | ref_ev | held_up;
            dn_q    <= dn_q | fb_ev | held_dn;
            held_up <= 1'b0;
            held_dn <= 1'b0;
            dly_cnt <= '0;
        end
    end
endmodule

// File: rtl/pfd_out_ctrl.sv
// pfd_out_ctrl: decodes the mode pins into pump enable, polarity and the
// monitor source. Purely combinational; assumes registered inputs.
module pfd_out_ctrl
    import pfd_synth_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       up_q,
    input  logic       dn_q,
    input  logic       ref_div,
    input  logic       fb_div,
    output logic       up_o,
    output logic       dn_o,
    output logic       cp_en_o,
    output logic       mux_o
);
    // Mode decode for all four outputs.
    always_comb begin
        unique case (mode_e'(mode_i))
            MD_ACTIVE_HI: begin cp_en_o = 1'b1; up_o = up_q;  dn_o = dn_q;  mux_o = 1'b1;    end
            MD_OPEN_REF:  begin cp_en_o = 1'b0; up_o = 1'b0;  dn_o = 1'b0;  mux_o = ref_div; end
            MD_ACTIVE_FB: begin cp_en_o = 1'b1; up_o = up_q;  dn_o = dn_q;  mux_o = fb_div;  end
            default:      begin cp_en_o = 1'b1; up_o = dn_q;  dn_o = up_q;  mux_o = 1'b0;    end
        endcase
    end
endmodule

// File: rtl/pfd_synth_core.sv
// pfd_synth_core: fixed reference halving, pin-selected feedback divider,
// phase-frequency detector with timed coincidence clear, and mode decode.
// Assumes all inputs are synchronous to clk and strobes last one cycle.
module pfd_synth_core #(
    parameter int REF_RATIO    = 2,
    parameter int FB_BASE_LOG2 = 3,
    parameter int CLR_DELAY    = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_stb,
    input  logic       fb_stb,
    input  logic [1:0] nsel_i,
    input  logic [1:0] mode_i,
    output logic       up_o,
    output logic       dn_o,
    output logic       cp_en_o,
    output logic       mux_o
);
    localparam int REF_CNT_W = (REF_RATIO > 2) ? $clog2(REF_RATIO) : 1;
    localparam int FB_CNT_W  = FB_BASE_LOG2 + 3;

    logic [1:0]          nsel_q;
    logic                sel_chg;
    logic [FB_CNT_W:0]   fb_pow;
    logic [FB_CNT_W-1:0] fb_last;
    logic                ref_div;
    logic                fb_div;
    logic                up_raw;
    logic                dn_raw;

    // Remember the select pins to detect a ratio change.
    always_ff @(posedge clk) begin
        if (!rst_n) nsel_q <= 2'b00;
        else        nsel_q <= nsel_i;
    end

    // Terminal count for the selected feedback ratio.
    always_comb begin
        sel_chg = (nsel_i != nsel_q);
        fb_pow  = (FB_CNT_W + 1)'(1) << (FB_BASE_LOG2 + int'(nsel_i));
        fb_last = fb_pow[FB_CNT_W-1:0] - FB_CNT_W'(1);
    end

    strobe_div #(.CNT_W(REF_CNT_W)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .clear_i(1'b0), .stb_i(ref_stb),
        .last_i(REF_CNT_W'(REF_RATIO - 1)), .div_o(ref_div)
    );

    strobe_div #(.CNT_W(FB_CNT_W)) u_fb_div (
        .clk(clk), .rst_n(rst_n), .clear_i(sel_chg), .stb_i(fb_stb),
        .last_i(fb_last), .div_o(fb_div)
    );

    pfd_detector #(.CLR_DELAY(CLR_DELAY)) u_det (
        .clk(clk), .rst_n(rst_n), .ref_ev(ref_div), .fb_ev(fb_div),
        .up_q(up_raw), .dn_q(dn_raw)
    );

    pfd_out_ctrl u_out (
        .mode_i(mode_i), .up_q(up_raw), .dn_q(dn_raw),
        .ref_div(ref_div), .fb_div(fb_div),
        .up_o(up_o), .dn_o(dn_o), .cp_en_o(cp_en_o), .mux_o(mux_o)
    );
endmodule

// File: rtl/pfd_synth_chk.sv
// pfd_synth_chk: temporal checks on the synthesizer core, bound to the top.
module pfd_synth_chk #(
    parameter int CLR_DELAY = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_stb,
    input logic       fb_stb,
    input logic [1:0] mode_i,
    input logic       ref_div,
    input logic       fb_div,
    input logic       up_raw,
    input logic       dn_raw,
    input logic       up_o,
    input logic       dn_o,
    input logic       cp_en_o,
    input logic       mux_o
);
    localparam int RUN_W = $clog2(CLR_DELAY + 2) + 1;

    logic [RUN_W-1:0] run;
    logic             both;

    always_comb both = up_raw & dn_raw;

    // Length of the current coincidence run.
    always_ff @(posedge clk) begin
        if (!rst_n)    run <= '0;
        else if (both) run <= run + 1'b1;
        else           run <= '0;
    end

    assert_ref_div_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div |-> $past(ref_stb));
    assert_ref_div_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_div |=> !ref_div);
    assert_fb_div_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_div |-> $past(fb_stb));
    assert_up_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (up_raw && !dn_raw) |=> up_raw);
    assert_dn_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_raw && !up_raw) |=> dn_raw);
    assert_overlap_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(both) |-> (run == RUN_W'(CLR_DELAY)));
    assert_joint_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        both |=> (up_raw == dn_raw));
    assert_mux_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b00) |-> mux_o);
    assert_open_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b01) |-> (!cp_en_o && !up_o && !dn_o));
    assert_swap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11) |-> (up_o == dn_raw && dn_o == up_raw && !mux_o));
endmodule

bind pfd_synth_core pfd_synth_chk #(.CLR_DELAY(CLR_DELAY)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
    .mode_i(mode_i), .ref_div(ref_div), .fb_div(fb_div),
    .up_raw(up_raw), .dn_raw(dn_raw), .up_o(up_o), .dn_o(dn_o),
    .cp_en_o(cp_en_o), .mux_o(mux_o)
);

// File: tb/pfd_synth_core_test.sv
module pfd_synth_core_test;
    localparam int DLY = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_stb = 1'b0;
    logic fb_stb = 1'b0;
    logic [1:0] nsel_i = 2'b00;
    logic [1:0] mode_i = 2'b00;
    logic up_o, dn_o, cp_en_o, mux_o;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfd_synth_core #(.CLR_DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fb_stb(fb_stb),
        .nsel_i(nsel_i), .mode_i(mode_i),
        .up_o(up_o), .dn_o(dn_o), .cp_en_o(cp_en_o), .mux_o(mux_o)
    );

    // Vector: {mode, nsel, ratio, up, dn, en, mux} after two reference strobes.
    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] nsel;
        logic [7:0] ratio;
        logic [3:0] outs;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{2'b00, 2'b00, 8'd8,  4'b1011},
        '{2'b01, 2'b01, 8'd16, 4'b0000},
        '{2'b10, 2'b10, 8'd32, 4'b1010},
        '{2'b11, 2'b11, 8'd64, 4'b0110}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_ref();
        @(negedge clk) ref_stb = 1'b1;
        @(negedge clk) ref_stb = 1'b0;
    endtask

    task automatic pulse_fb();
        @(negedge clk) fb_stb = 1'b1;
        @(negedge clk) fb_stb = 1'b0;
    endtask

    // Feed feedback strobes until dn_o rises (mode 00) and return the count.
    task automatic count_fb(output int n);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            pulse_fb();
            n++;
            @(negedge clk);
            if (dn_o) break;
        end
    endtask

    initial begin
        int n;
        int run;
        // Table walk: ratio (R2) and per-mode outputs (R6..R9).
        for (int v = 0; v < 4; v++) begin
            mode_i = 2'b00; nsel_i = VECS[v].nsel;
            do_reset();
            count_fb(n);
            check($sformatf("R2 nsel=%0d ratio", VECS[v].nsel), n, VECS[v].ratio);
            mode_i = VECS[v].mode;
            do_reset();
            pulse_ref(); pulse_ref();
            @(negedge clk);
            check($sformatf("R6 R7 R8 R9 mode=%0d {up,dn,en,mux}", VECS[v].mode),
                  {up_o, dn_o, cp_en_o, mux_o}, VECS[v].outs);
        end

        // R11: reset state in mode 00.
        mode_i = 2'b00; nsel_i = 2'b00;
        do_reset();
        @(negedge clk);
        check("R11 reset {up,dn,en,mux}", {up_o, dn_o, cp_en_o, mux_o}, 4'b0011);

        // R1: one strobe is not enough; rise is two cycles after the second.
        pulse_ref();
        @(negedge clk); @(negedge clk);
        check("R1 single strobe up", up_o, 0);
        pulse_ref();
        check("R1 up before detector edge", up_o, 0);
        @(negedge clk);
        check("R1 up after second strobe", up_o, 1);
        repeat (4) @(negedge clk);
        check("R3 up holds", up_o, 1);

        // R11: reset mid-run clears the detector.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R11 up cleared", up_o, 0);
        rst_n = 1'b1;

        // R4: overlap lasts exactly DLY cycles, then both clear.
        do_reset();
        pulse_ref(); pulse_ref();
        repeat (8) pulse_fb();
        run = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (up_o && dn_o) run++;
            else break;
        end
        check("R4 overlap length", run, DLY);
        check("R4 both cleared", {up_o, dn_o}, 2'b00);

        // R5: reference strobe landing inside the window is deferred.
        do_reset();
        pulse_ref(); pulse_ref();
        pulse_ref();
        repeat (8) pulse_fb();
        pulse_ref();
        @(negedge clk); @(negedge clk);
        check("R5 cleared in window end", {up_o, dn_o}, 2'b00);
        @(negedge clk);
        check("R5 deferred up", {up_o, dn_o}, 2'b10);

        // R7: open loop hides state, detector state survives.
        do_reset();
        pulse_ref(); pulse_ref();
        @(negedge clk) mode_i = 2'b01;
        @(negedge clk);
        check("R7 open {up,dn,en}", {up_o, dn_o, cp_en_o}, 3'b000);
        pulse_fb();
        @(negedge clk) mode_i = 2'b00;
        @(negedge clk);
        check("R7 state kept", {up_o, dn_o}, 2'b10);

        // R7: monitor shows divided reference strobe.
        mode_i = 2'b01;
        do_reset();
        pulse_ref(); pulse_ref();
        check("R7 mux strobe", mux_o, 1);
        @(negedge clk);
        check("R7 mux strobe end", mux_o, 0);

        // R8: monitor shows divided feedback strobe.
        mode_i = 2'b10; nsel_i = 2'b00;
        do_reset();
        repeat (7) pulse_fb();
        check("R8 mux before last", mux_o, 0);
        pulse_fb();
        check("R8 mux strobe", mux_o, 1);
        @(negedge clk);
        check("R8 mux strobe end", mux_o, 0);

        // R10: ratio change restarts the count.
        mode_i = 2'b00; nsel_i = 2'b00;
        do_reset();
        repeat (5) pulse_fb();
        @(negedge clk) nsel_i = 2'b01;
        @(negedge clk);
        count_fb(n);
        check("R10 count after select change", n, 16);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule